// File: doc/BRIEF.md
# Single-Step Shift and Sign-Extension Unit

This unit serves the one-operand shift and widen group of a small RISC execution stage. Each cycle it takes a data word, a three-bit operation code and the processor's current carry flag. It returns a result word, the carry value to be committed and a strobe that tells the flag logic whether to commit that value. All outputs are registered, so a result appears one clock after its operands are presented.

Three operations move the word one place toward bit 0. They differ only in what fills the vacated top bit: a copy of the old sign bit, the incoming carry flag, or zero. Each of the three returns the bit that drops off the bottom as the new carry. The other two operations widen a signed byte or a signed halfword to the full data width and do not touch the carry flag. Codes that select no operation return the operand unchanged.

Top module: `shx_unit`

## Requirements
- R1: Operation code 0 (arithmetic shift) yields result[30:0] = operand[31:1] and result[31] = operand[31].
- R2: Operation code 1 (rotate through carry) yields result[30:0] = operand[31:1] and result[31] = the carry input.
- R3: Operation code 2 (logical shift) yields result[30:0] = operand[31:1] and result[31] = 0.
- R4: For codes 0, 1 and 2, carry_out equals operand bit 0 and carry_we is 1.
- R5: Operation code 3 yields result[7:0] = operand[7:0], with every bit of result[31:8] equal to operand bit 7.
- R6: Operation code 4 yields result[15:0] = operand[15:0], with every bit of result[31:16] equal to operand bit 15.
- R7: For any code other than 0, 1 and 2, carry_we is 0 and carry_out repeats the carry input, so the flag keeps its value.
- R8: Codes 5, 6 and 7 return the operand unchanged in result.
- R9: Outputs change one clock after the inputs are sampled; while rst is high at a clock edge, result, carry_out and carry_we are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| operand | input | 32 | Data word to shift or extend |
| op_code | input | 3 | Operation select (0 to 4 used) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered result word |
| carry_out | output | 1 | Registered new carry value |
| carry_we | output | 1 | Registered carry commit strobe |

## Verification
The bench aims at the top bit of the three shifts with operands whose sign and bit 0 differ from the carry input. A design that mixed up the fill sources would put the sign where the carry belongs, or leave a stale one in a logical shift. Operands with bit 7 or bit 15 set while the higher bits are clear, and the reverse, expose an extension taken from the wrong bit position. Random codes 3 to 7, with the carry input toggling, catch a carry strobe raised for a non-shift or an unused code that alters the word instead of passing it through.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int SHX_DATA_W = 32;
    localparam int SHX_OP_W   = 3;

    typedef enum logic [SHX_OP_W-1:0] {
        OP_ASR  = 3'd0,
        OP_SRC  = 3'd1,
        OP_SRL  = 3'd2,
        OP_SX8  = 3'd3,
        OP_SX16 = 3'd4
    } shx_op_e;

    // Source of the vacated top bit in a one-place right shift.
    typedef enum logic [1:0] {
        FILL_SIGN  = 2'd0,
        FILL_CARRY = 2'd1,
        FILL_ZERO  = 2'd2
    } fill_e;

    typedef struct packed {
        logic cy;
        logic cy_we;
    } cy_ctl_t;

    function automatic logic is_shift(input logic [SHX_OP_W-1:0] code);
        return (code == OP_ASR) || (code == OP_SRC) || (code == OP_SRL);
    endfunction

    function automatic logic is_extend(input logic [SHX_OP_W-1:0] code);
        return (code == OP_SX8) || (code == OP_SX16);
    endfunction

    function automatic fill_e fill_of(input logic [SHX_OP_W-1:0] code);
        fill_e f;
        case (code)
            OP_ASR:  f = FILL_SIGN;
            OP_SRC:  f = FILL_CARRY;
            default: f = FILL_ZERO;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/shx_shift1.sv
module shx_shift1
    import shx_pkg::*;
#(
    parameter int W = SHX_DATA_W
) (
    input  logic [W-1:0] a,
    input  fill_e        fill,
    input  logic         cin,
    output logic [W-1:0] y,
    output logic         cy
);
    logic top_bit;

    always_comb begin
        case (fill)
            FILL_SIGN:  top_bit = a[W-1];
            FILL_CARRY: top_bit = cin;
            default:    top_bit = 1'b0;
        endcase
        y  = {top_bit, a[W-1:1]};
        cy = a[0];
    end
endmodule

// File: rtl/shx_sext.sv
module shx_sext
    import shx_pkg::*;
#(
    parameter int W      = SHX_DATA_W,
    parameter int NARROW = 8,
    parameter int WIDE   = 16
) (
    input  logic [W-1:0] a,
    input  logic         sel_wide,
    output logic [W-1:0] y
);
    localparam int NPAD = W - NARROW;
    localparam int WPAD = W - WIDE;

    logic [W-1:0] ext_n;
    logic [W-1:0] ext_w;

    generate
        if (NPAD > 0) begin : g_narrow
            assign ext_n = {{NPAD{a[NARROW-1]}}, a[NARROW-1:0]};
        end else begin : g_narrow_id
            assign ext_n = a;
        end
        if (WPAD > 0) begin : g_wide
            assign ext_w = {{WPAD{a[WIDE-1]}}, a[WIDE-1:0]};
        end else begin : g_wide_id
            assign ext_w = a;
        end
    endgenerate

    assign y = sel_wide ? ext_w : ext_n;
endmodule

// File: rtl/shx_unit.sv
module shx_unit
    import shx_pkg::*;
#(
    parameter int DATA_W = SHX_DATA_W,
    parameter int OP_W   = SHX_OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] operand,
    input  logic [OP_W-1:0]   op_code,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              carry_we
);
    logic [DATA_W-1:0] shift_y;
    logic              shift_cy;
    logic [DATA_W-1:0] ext_y;
    logic [DATA_W-1:0] next_y;
    cy_ctl_t           next_ctl;

    shx_shift1 #(.W(DATA_W)) u_shift (
        .a    (operand),
        .fill (fill_of(op_code)),
        .cin  (carry_in),
        .y    (shift_y),
        .cy   (shift_cy)
    );

    shx_sext #(.W(DATA_W), .NARROW(8), .WIDE(16)) u_sext (
        .a        (operand),
        .sel_wide (op_code == OP_SX16),
        .y        (ext_y)
    );

    always_comb begin
        if (is_shift(op_code)) begin
            next_y         = shift_y;
            next_ctl.cy    = shift_cy;
            next_ctl.cy_we = 1'b1;
        end else begin
            next_y         = is_extend(op_code) ? ext_y : operand;
            next_ctl.cy    = carry_in;
            next_ctl.cy_we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            carry_out <= 1'b0;
            carry_we  <= 1'b0;
        end else begin
            result    <= next_y;
            carry_out <= next_ctl.cy;
            carry_we  <= next_ctl.cy_we;
        end
    end

    // Assertions sit next to the output register they guard.
    a_r1_asr_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_ASR) |->
            (result[DATA_W-1] == $past(operand[DATA_W-1]) &&
             result[DATA_W-2:0] == $past(operand[DATA_W-1:1])));

    a_r2_src_carry_top: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_SRC) |->
            (result[DATA_W-1] == $past(carry_in)));

    a_r3_srl_zero_top: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_SRL) |->
            (result[DATA_W-1] == 1'b0));

    a_r4_shift_carry_lsb: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && is_shift($past(op_code))) |->
            (carry_we && carry_out == $past(operand[0])));

    a_r5_sx8_upper_uniform: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_SX8) |->
            ($countones(result[DATA_W-1:7]) == 0 ||
             $countones(result[DATA_W-1:7]) == DATA_W - 7));

    a_r6_sx16_upper_uniform: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_SX16) |->
            ($countones(result[DATA_W-1:15]) == 0 ||
             $countones(result[DATA_W-1:15]) == DATA_W - 15));

    a_r7_no_carry_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !is_shift($past(op_code))) |->
            (!carry_we && carry_out == $past(carry_in)));

    a_r8_unused_passthrough: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !is_shift($past(op_code)) && !is_extend($past(op_code))) |->
            (result == $past(operand)));

    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (result == '0 && !carry_out && !carry_we));
endmodule

// File: tb/tb_shx_unit.sv
module tb_shx_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] operand;
    logic [2:0]  op_code;
    logic        carry_in;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shx_unit dut (
        .clk(clk), .rst(rst), .operand(operand), .op_code(op_code),
        .carry_in(carry_in), .result(result), .carry_out(carry_out),
        .carry_we(carry_we)
    );

    // Expected {result, carry_out, carry_we} from the requirements.
    function automatic logic [33:0] model(input logic [31:0] a,
                                          input logic [2:0] op,
                                          input logic c);
        case (op)
            3'd0:    return {{a[31], a[31:1]}, a[0], 1'b1};             // R1 R4
            3'd1:    return {{c, a[31:1]}, a[0], 1'b1};                 // R2 R4
            3'd2:    return {{1'b0, a[31:1]}, a[0], 1'b1};              // R3 R4
            3'd3:    return {{{24{a[7]}}, a[7:0]}, c, 1'b0};            // R5 R7
            3'd4:    return {{{16{a[15]}}, a[15:0]}, c, 1'b0};          // R6 R7
            default: return {a, c, 1'b0};                               // R8 R7
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1/R4";
            3'd1: return "R2/R4";
            3'd2: return "R3/R4";
            3'd3: return "R5/R7";
            3'd4: return "R6/R7";
            default: return "R8/R7";
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [2:0] op, input logic c);
        logic [33:0] exp;
        @(negedge clk);
        operand  = a;
        op_code  = op;
        carry_in = c;
        exp = model(a, op, c);
        @(posedge clk);
        @(negedge clk);   // R9: registered output, one cycle later
        checks++;
        if ({result, carry_out, carry_we} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h c=%b: got %h/%b/%b expected %h/%b/%b",
                     req_of(op), op, a, c, result, carry_out, carry_we,
                     exp[33:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; operand = 32'hFFFF_FFFF; op_code = 3'd1; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R9 reset state
        if (result !== 32'h0 || carry_out !== 1'b0 || carry_we !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: got %h/%b/%b expected 0/0/0", result, carry_out, carry_we);
        end
        rst = 1'b0;

        // Directed corner cases
        apply(32'h8000_0001, 3'd0, 1'b0);   // R1 sign kept, R4 carry 1
        apply(32'h7FFF_FFFE, 3'd0, 1'b1);   // R1 positive
        apply(32'h0000_0001, 3'd1, 1'b1);   // R2 carry into top
        apply(32'h8000_0000, 3'd1, 1'b0);   // R2 sign not used
        apply(32'h8000_0001, 3'd2, 1'b1);   // R3 top forced 0
        apply(32'h0000_0080, 3'd3, 1'b1);   // R5 negative byte
        apply(32'hFFFF_FF7F, 3'd3, 1'b0);   // R5 positive byte, upper cleared
        apply(32'h0000_8000, 3'd4, 1'b0);   // R6 negative half
        apply(32'hFFFF_7FFF, 3'd4, 1'b1);   // R6 positive half
        apply(32'hDEAD_BEEF, 3'd5, 1'b1);   // R8 R7
        apply(32'h1234_5678, 3'd6, 1'b0);   // R8
        apply(32'hA5A5_A5A5, 3'd7, 1'b1);   // R8

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, 3'($urandom_range(0, 7)), 1'($urandom));
        end

        // R9: reset in the middle clears outputs on the next edge
        @(negedge clk);
        operand = 32'hFFFF_FFFF; op_code = 3'd1; carry_in = 1'b1; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== 32'h0 || carry_out !== 1'b0 || carry_we !== 1'b0) begin
            errors++;
            $display("FAIL R9 mid reset: got %h/%b/%b expected 0/0/0", result, carry_out, carry_we);
        end
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule